// File: doc/BRIEF.md
# Store Buffer with Fences

This block sits between an in-order load/store pipeline and a single-ported memory write/read port. Stores that the pipeline retires are not written at once: they go into an in-order queue and are committed to memory later, one per cycle, whenever the memory port is granted and no load is using it. Loads do not wait behind older buffered stores. A load whose address matches a buffered store takes its data from the youngest such entry. A load that matches nothing reads memory directly, ahead of the stores still queued.

The pipeline also sends ordering requests: a full fence, a store-only fence and a load-only fence. It can also send locked read-modify-write operations (atomic OR and exchange-add). Each of these holds back the request stream in its own way. A full fence waits until the queue is empty. A store fence holds later stores until the queue has drained and lets loads through. A load fence has no effect, because loads already complete in order. A locked operation first waits for the queue to empty, then reads and writes its word in a single locked memory cycle and returns the old value.

Top module: `store_order_buffer`

## Requirements
- R1: A store is accepted into the queue without a memory write in its acceptance cycle. It is written to memory no earlier than the following cycle.
- R2: Buffered stores reach memory strictly in acceptance order, at most one per cycle, and only in cycles where `memReady` is high.
- R3: A load (reqOp=1) whose address matches one or more buffered stores returns the data of the youngest match. It needs no memory grant, and `rspValid` rises in the cycle after acceptance.
- R4: A load to an address that no buffered entry holds reads memory while older stores to other addresses are still queued. It returns the memory word one cycle after acceptance.
- R5: In a cycle where a load that missed the queue is granted the port, no store commits (memEn=1, memWe=0).
- R6: With 8 entries held, a new store (reqOp=0) sees `reqReady` low until an entry has committed.
- R7: A full fence (reqOp=4) keeps `reqReady` low until every earlier store has been written to memory.
- R8: After a store fence (reqOp=2), later stores wait until all earlier stores have committed, while loads are still accepted at once.
- R9: A load fence (reqOp=3) is accepted at once, and neither later stores nor the commit stream are held back by it.
- R10: A locked operation (reqOp=5 OR, reqOp=6 add) waits until the queue is empty and the port is granted. It then reads and writes its word in one cycle with `memLock` high, and returns the old value one cycle later.
- R11: After reset the queue is empty, `reqReady` is high, and `rspValid` and `memEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request from the pipeline is valid |
| reqReady | output | 1 | Request is accepted at this clock edge |
| reqOp | input | 3 | 0 store, 1 load, 2 store fence, 3 load fence, 4 full fence, 5 locked OR, 6 locked add, 7 no-op |
| reqAddr | input | AW | Word address |
| reqData | input | DW | Store data or locked operand |
| rspValid | output | 1 | Load or locked-operation result is valid |
| rspData | output | DW | Loaded or old value |
| memReady | input | 1 | Memory port is granted this cycle |
| memEn | output | 1 | Memory access this cycle |
| memWe | output | 1 | Access writes memory |
| memLock | output | 1 | Access is an indivisible read-modify-write |
| memAddr | output | AW | Access address |
| memWdata | output | DW | Write data |
| memRdata | input | DW | Combinational read data for memAddr |

## Verification
Two functions can compete for the single memory port in the same cycle: a load that missed the queue and the commit of the oldest buffered store. The bench provokes this by filling the queue while the grant is withheld. It then issues a miss to a preloaded address and restores the grant in that same cycle. It judges the result by seeing the port read without a write and the store still pending. The load's value must come from memory, and the store's commit must follow in order afterwards. A scoreboard checks every commit against program order and every response against an architectural model.

// File: rtl/sob_pkg.sv
package sob_pkg;

  typedef enum logic [2:0] {
    OP_STORE    = 3'd0,
    OP_LOAD     = 3'd1,
    OP_SFENCE   = 3'd2,
    OP_LFENCE   = 3'd3,
    OP_MFENCE   = 3'd4,
    OP_LOCK_OR  = 3'd5,
    OP_LOCK_ADD = 3'd6,
    OP_NOP      = 3'd7
  } sob_op_e;

  typedef struct packed {
    logic push;        // enqueue the request as a buffered store
    logic pop;         // commit the oldest entry this cycle
    logic memRead;     // load miss owns the port
    logic atomic;      // locked read-modify-write owns the port
    logic atomicAdd;   // 1: add, 0: OR
    logic rspCapture;  // register a response for next cycle
  } sob_strobe_t;

endpackage

// File: rtl/sob_control.sv
module sob_control
  import sob_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  reqOp,
  input  logic        bufFull,
  input  logic        bufEmpty,
  input  logic        fwdHit,
  input  logic        memReady,
  output logic        reqReady,
  output sob_strobe_t strb
);

  sob_op_e opCode;
  logic    fenceHold;
  logic    accept;
  logic    isLock;

  assign opCode = sob_op_e'(reqOp);
  assign isLock = (opCode == OP_LOCK_OR) || (opCode == OP_LOCK_ADD);

  always_comb begin
    unique case (opCode)
      OP_STORE:    reqReady = !bufFull && !(fenceHold && !bufEmpty);
      OP_LOAD:     reqReady = fwdHit || memReady;
      OP_MFENCE:   reqReady = bufEmpty;
      OP_LOCK_OR,
      OP_LOCK_ADD: reqReady = bufEmpty && memReady;
      default:     reqReady = 1'b1;
    endcase
  end

  assign accept = reqValid && reqReady;

  always_comb begin
    strb            = '0;
    strb.push       = accept && (opCode == OP_STORE);
    strb.memRead    = accept && (opCode == OP_LOAD) && !fwdHit;
    strb.atomic     = accept && isLock;
    strb.atomicAdd  = opCode == OP_LOCK_ADD;
    strb.rspCapture = accept && ((opCode == OP_LOAD) || isLock);
    strb.pop        = !bufEmpty && memReady && !strb.memRead && !strb.atomic;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fenceHold <= 1'b0;
    end else if (accept && (opCode == OP_SFENCE) && !bufEmpty) begin
      fenceHold <= 1'b1;
    end else if (bufEmpty) begin
      fenceHold <= 1'b0;
    end
  end

  AST_LOAD_NOT_FENCED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opCode == OP_LOAD && memReady) |-> reqReady); // R8

  AST_MFENCE_DRAINED: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opCode == OP_MFENCE) |-> bufEmpty); // R7

endmodule

// File: rtl/sob_datapath.sv
module sob_datapath
  import sob_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  sob_strobe_t   strb,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqData,
  input  logic [DW-1:0] memRdata,
  output logic          bufFull,
  output logic          bufEmpty,
  output logic          fwdHit,
  output logic          memEn,
  output logic          memWe,
  output logic          memLock,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          rspValid,
  output logic [DW-1:0] rspData
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addrMem [DEPTH];
  logic [DW-1:0] dataMem [DEPTH];
  logic [PW-1:0] headPtr, tailPtr;
  logic [CW-1:0] count;
  logic [DW-1:0] fwdData;
  logic [PW-1:0] scanIdx;

  assign bufFull  = count == CW'(DEPTH);
  assign bufEmpty = count == '0;

  // Youngest matching entry wins: scan from oldest to youngest, last hit kept.
  always_comb begin
    fwdHit  = 1'b0;
    fwdData = '0;
    scanIdx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      scanIdx = headPtr + PW'(i);
      if ((CW'(i) < count) && (addrMem[scanIdx] == reqAddr)) begin
        fwdHit  = 1'b1;
        fwdData = dataMem[scanIdx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push) begin
      addrMem[tailPtr] <= reqAddr;
      dataMem[tailPtr] <= reqData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      if (strb.push) tailPtr <= tailPtr + 1'b1;
      if (strb.pop)  headPtr <= headPtr + 1'b1;
      count <= count + CW'(strb.push) - CW'(strb.pop);
    end
  end

  assign memEn   = strb.memRead || strb.atomic || strb.pop;
  assign memWe   = strb.atomic || strb.pop;
  assign memLock = strb.atomic;
  assign memAddr = (strb.memRead || strb.atomic) ? reqAddr : addrMem[headPtr];

  always_comb begin
    if (strb.atomic) begin
      memWdata = strb.atomicAdd ? (memRdata + reqData) : (memRdata | reqData);
    end else begin
      memWdata = dataMem[headPtr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.rspCapture;
      if (strb.rspCapture) rspData <= (fwdHit && !strb.atomic) ? fwdData : memRdata;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R6

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> !bufFull); // R6

  AST_LOCK_DRAINED: assert property (@(posedge clk) disable iff (!rstN)
    strb.atomic |-> bufEmpty); // R10

  AST_ONE_PORT_USER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.memRead, strb.atomic, strb.pop})); // R5

  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    strb.rspCapture |=> rspValid); // R3

endmodule

// File: rtl/store_order_buffer.sv
module store_order_buffer
  import sob_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [2:0]    reqOp,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqData,
  output logic          rspValid,
  output logic [DW-1:0] rspData,
  input  logic          memReady,
  output logic          memEn,
  output logic          memWe,
  output logic          memLock,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata
);

  sob_strobe_t strb;
  logic        bufFull, bufEmpty, fwdHit;

  sob_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .bufFull  (bufFull),
    .bufEmpty (bufEmpty),
    .fwdHit   (fwdHit),
    .memReady (memReady),
    .reqReady (reqReady),
    .strb     (strb)
  );

  sob_datapath #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .memRdata (memRdata),
    .bufFull  (bufFull),
    .bufEmpty (bufEmpty),
    .fwdHit   (fwdHit),
    .memEn    (memEn),
    .memWe    (memWe),
    .memLock  (memLock),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .rspValid (rspValid),
    .rspData  (rspData)
  );

endmodule

// File: tb/store_order_buffer_tb.sv
module store_order_buffer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [2:0]    reqOp = 3'd7;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic          rspValid;
  logic [DW-1:0] rspData;
  logic          memReady = 1'b1;
  logic          memEn, memWe, memLock;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata;

  logic [DW-1:0] memArr [256];
  logic [DW-1:0] refMem [256];

  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } wr_t;
  wr_t           expWr [$];
  logic [DW-1:0] expRsp [$];

  int total = 0;
  int bad = 0;
  int lockWrites = 0;
  logic accWe, accEn, accLock;
  int   accPend;
  bit   finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_order_buffer u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData),
    .rspValid(rspValid), .rspData(rspData), .memReady(memReady),
    .memEn(memEn), .memWe(memWe), .memLock(memLock), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  assign memRdata = memArr[memAddr[7:0]];

  always @(posedge clk) begin
    if (memEn && memWe) memArr[memAddr[7:0]] <= memWdata;
  end

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: commits in program order, responses against the model.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (memEn && memWe && !memLock) begin
        if (expWr.size() == 0) begin
          check(1'b0, "R2 unexpected commit", {16'd0, memAddr}, 0);
        end else begin
          wr_t e;
          e = expWr.pop_front();
          check(memAddr == e.a && memWdata == e.d, "R2 commit order",
                {memAddr, memWdata[15:0]}, {e.a, e.d[15:0]});
        end
      end
      if (memEn && memLock) lockWrites++;
      if (rspValid) begin
        if (expRsp.size() == 0) begin
          check(1'b0, "R3 unexpected response", rspData, 0);
        end else begin
          logic [DW-1:0] e;
          e = expRsp.pop_front();
          check(rspData == e, "R3/R4/R10 response data", rspData, e);
        end
      end
    end
  end

  // Driver: called at posedge+1, returns at posedge+1.
  task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int relAfter, output int stalls);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqData = d;
    stalls = 0;
    forever begin
      @(negedge clk);
      if (reqReady) break;
      stalls++;
      @(posedge clk); #1;
      if (relAfter >= 0 && stalls >= relAfter) memReady = 1'b1;
    end
    accWe = memWe; accEn = memEn; accLock = memLock; accPend = expWr.size();
    case (op)
      3'd0: begin expWr.push_back({a, d}); refMem[a[7:0]] = d; end
      3'd1: expRsp.push_back(refMem[a[7:0]]);
      3'd5: begin expRsp.push_back(refMem[a[7:0]]); refMem[a[7:0]] = refMem[a[7:0]] | d; end
      3'd6: begin expRsp.push_back(refMem[a[7:0]]); refMem[a[7:0]] = refMem[a[7:0]] + d; end
      default: ;
    endcase
    @(posedge clk); #1;
    reqValid = 1'b0; reqOp = 3'd7;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    int s;
    for (int i = 0; i < 256; i++) begin memArr[i] = '0; refMem[i] = '0; end
    memArr[8'h50] = 32'hABCD; refMem[8'h50] = 32'hABCD;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R11 reqReady after reset", reqReady, 1);
    check(rspValid == 1'b0, "R11 rspValid after reset", rspValid, 0);
    check(memEn == 1'b0, "R11 memEn after reset", memEn, 0);
    @(posedge clk); #1;

    // R1: store is not written in its acceptance cycle
    issue(3'd0, 16'h10, 32'h11, -1, s);
    check(accWe == 1'b0, "R1 no write at acceptance", accWe, 0);
    check(memArr[8'h10] == '0, "R1 memory unchanged at acceptance", memArr[8'h10], 0);
    idle(2);
    check(memArr[8'h10] == 32'h11, "R1 store committed later", memArr[8'h10], 32'h11);
    issue(3'd1, 16'h10, 0, -1, s);

    // R6, R3: fill queue with grant withheld, forward youngest
    memReady = 1'b0;
    issue(3'd0, 16'h20, 32'h1, -1, s);
    issue(3'd0, 16'h20, 32'h2, -1, s);
    for (int i = 0; i < 6; i++) issue(3'd0, AW'(16'h21 + i), DW'(32'h100 + i), -1, s);
    issue(3'd1, 16'h20, 0, -1, s);
    check(s == 0, "R3 forwarding load needs no grant", s, 0);
    check(accEn == 1'b0, "R3 forwarding load uses no port", accEn, 0);
    issue(3'd0, 16'h27, 32'h9, 3, s);
    check(s > 0, "R6 store stalled while full", s, 1);
    idle(12);
    check(expWr.size() == 0, "R2 queue drained", expWr.size(), 0);

    // R4, R5: load miss and commit in the same cycle
    memReady = 1'b0;
    issue(3'd0, 16'h30, 32'h33, -1, s);
    issue(3'd1, 16'h50, 0, 1, s);
    check(accEn && !accWe, "R5 load miss owns port, no commit", {accEn, accWe}, 2'b10);
    check(accPend == 1, "R4 load passed older store", accPend, 1);
    idle(3);
    check(memArr[8'h30] == 32'h33, "R4 store committed after load", memArr[8'h30], 32'h33);

    // R7: full fence waits for drain
    memReady = 1'b0;
    issue(3'd0, 16'h40, 32'h4, -1, s);
    issue(3'd0, 16'h41, 32'h5, -1, s);
    issue(3'd4, 0, 0, 2, s);
    check(s >= 3, "R7 full fence stalled", s, 3);
    check(accPend == 0, "R7 earlier stores written before fence", accPend, 0);

    // R8: store fence holds stores, not loads
    memReady = 1'b0;
    issue(3'd0, 16'h42, 32'h6, -1, s);
    issue(3'd2, 0, 0, -1, s);
    check(s == 0, "R8 store fence accepted at once", s, 0);
    issue(3'd1, 16'h42, 0, -1, s);
    check(s == 0, "R8 load not held by store fence", s, 0);
    issue(3'd0, 16'h43, 32'h7, 2, s);
    check(s > 0, "R8 later store held", s, 1);
    check(accPend == 0, "R8 earlier store committed first", accPend, 0);
    idle(3);

    // R9: load fence has no effect
    memReady = 1'b0;
    issue(3'd0, 16'h44, 32'h8, -1, s);
    issue(3'd3, 0, 0, -1, s);
    check(s == 0, "R9 load fence accepted at once", s, 0);
    issue(3'd0, 16'h45, 32'h9, -1, s);
    check(s == 0, "R9 store after load fence not held", s, 0);
    check(accPend == 1, "R9 buffer not drained by load fence", accPend, 1);
    memReady = 1'b1;
    idle(4);
    check(expWr.size() == 0, "R9 commit stream continues", expWr.size(), 0);

    // R10: locked operations
    memReady = 1'b0;
    issue(3'd0, 16'h60, 32'h7, -1, s);
    issue(3'd6, 16'h60, 32'h3, 1, s);
    check(s > 0, "R10 locked add waits for drain", s, 1);
    check(accPend == 0, "R10 queue empty at locked op", accPend, 0);
    check(accLock == 1'b1 && accWe == 1'b1, "R10 locked read-write cycle", {accLock, accWe}, 2'b11);
    issue(3'd5, 16'h60, 32'h0, -1, s);
    idle(3);
    check(memArr[8'h60] == 32'hA, "R10 memory after add and OR", memArr[8'h60], 32'hA);
    check(lockWrites == 2, "R10 two locked cycles", lockWrites, 2);
    check(expRsp.size() == 0 && expWr.size() == 0, "R2 scoreboard empty",
          expRsp.size() + expWr.size(), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule